// File: doc/BRIEF.md
# SAR ADC Conversion Sequencer

This block runs one conversion-and-readback cycle on a successive-approximation converter attached over a serial link. On a start request it strobes the converter, waits out the conversion time without disturbing the data line, then clocks the result in and presents it as a 32-bit word with a one-cycle valid pulse. All waits are counted in system clock cycles. Each wait is taken from a nanosecond figure and rounded up to whole cycles of the configured clock period.

Two board wirings are supported and selected per request. In the first, the converter has its own convert line and the chip select is a separate pin. In the second, the convert input is tied to chip select, so a single line both starts the conversion and frames the read. A turbo flag picks the shorter conversion time. A width select picks a 14, 16 or 18-bit result. The 18-bit result is two's complement and the two narrower results are unsigned.

Top module: `adc_conv_seq`

## Requirements
- R1: After reset, `cnv_o` is 0, `cs_no` is 1, `sclk_o` is 0, `busy_o` is 0, `valid_o` is 0 and `data_o` is 0.
- R2: With `tied_mode_i`=0, `cnv_o` and `busy_o` rise in the first cycle after the start request is taken. `cs_no` stays 1 for exactly the conversion wait. `cs_no` then goes low for the read. `cnv_o` stays 1 until the read finishes and returns to 0 in the cycle `valid_o` is high.
- R3: With `tied_mode_i`=1, `cnv_o` stays 0. `cs_no` goes low for a quiet time of ceil(20 ns / clock period) cycles (5 at 250 MHz), then high for exactly the conversion wait, then low for the read.
- R4: The conversion wait in cycles is ceil(t / clock period), where t is 420 ns (normal) or 320 ns (turbo) for 14 and 16-bit widths, and 500 ns or 400 ns for the 18-bit width. The wait is never shorter than a 10 ns strobe. At 250 MHz the waits are 105/80 and 125/100 cycles.
- R5: `width_sel_i` is sampled with the start request. Code 0 selects 14 bits, code 1 selects 16 bits, and codes 2 and 3 select 18 bits. The read issues exactly that many `sclk_o` rising edges.
- R6: `sclk_o` idles low and is high only while `cs_no` is 0 and `busy_o` is 1. `miso_i` is sampled on each rising edge of `sclk_o`, most significant bit first.
- R7: An 18-bit result is sign-extended from bit 17 into `data_o[31:0]`. A 14 or 16-bit result sits in the low bits of `data_o` with all higher bits 0.
- R8: `valid_o` is high for exactly one cycle, in the cycle where `busy_o` has returned to 0. `data_o` changes only in that cycle and holds afterwards.
- R9: A start request while `busy_o` is 1 is ignored. The sequence length is unchanged and no second result follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request one conversion and read |
| tied_mode_i | input | 1 | 1: convert tied to chip select; 0: separate convert line |
| turbo_i | input | 1 | Select the shorter conversion wait |
| width_sel_i | input | 2 | Result width code (0:14, 1:16, 2/3:18) |
| miso_i | input | 1 | Serial data from the converter |
| cnv_o | output | 1 | Convert line in separate-line wiring |
| cs_no | output | 1 | Chip select, active low (also the convert line when tied) |
| sclk_o | output | 1 | Serial clock, idle low |
| busy_o | output | 1 | Sequence in progress |
| data_o | output | 32 | Formatted result |
| valid_o | output | 1 | One-cycle strobe marking a new result |

## Verification
Several properties are checked on every cycle. The serial clock is only active inside a selected read. The convert line rises only when a sequence starts and does not drop before the result is delivered. The result strobe is a single cycle at idle, and the data word holds between strobes. Counters in the checker also give lower bounds on the quiet time and the conversion wait, and confirm that the number of clock edges is one of the three legal widths. Some properties can only be shown by the bench scenarios, which use a converter model. These are the exact wait for each width and turbo combination, the bit order, the sign handling, and the fact that a start during a sequence leaves its length unchanged.

// File: rtl/adc_conv_seq_pkg.sv
`timescale 1ns/1ps
package adc_conv_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_QUIET,
    ST_CONV,
    ST_READ
  } seq_state_e;

  localparam int unsigned W_SHORT = 14;
  localparam int unsigned W_MID   = 16;
  localparam int unsigned W_LONG  = 18;

  // nanoseconds to clock cycles, rounded up
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned period_ps);
    return (ns * 1000 + period_ps - 1) / period_ps;
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/adc_conv_seq_timer.sv
`timescale 1ns/1ps
module adc_conv_seq_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/adc_conv_seq_shifter.sv
`timescale 1ns/1ps
module adc_conv_seq_shifter #(
  parameter int unsigned SCLK_HALF = 2,
  parameter int unsigned MAX_W     = 18,
  localparam int unsigned HC_W     = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1,
  localparam int unsigned BIT_W    = $clog2(MAX_W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_i,
  input  logic [BIT_W-1:0] nbits_i,
  input  logic             miso_i,
  output logic             sclk_o,
  output logic             done_o,
  output logic [MAX_W-1:0] raw_o
);

  localparam logic [HC_W-1:0] HC_RELOAD = HC_W'(SCLK_HALF - 1);

  logic             active_q;
  logic [HC_W-1:0]  hcnt_q;
  logic [BIT_W-1:0] bcnt_q;
  logic             sclk_q;
  logic             done_q;
  logic [MAX_W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      hcnt_q   <= '0;
      bcnt_q   <= '0;
      sclk_q   <= 1'b0;
      done_q   <= 1'b0;
      sr_q     <= '0;
    end else begin
      done_q <= 1'b0;
      if (go_i) begin
        active_q <= 1'b1;
        hcnt_q   <= HC_RELOAD;
        bcnt_q   <= '0;
        sclk_q   <= 1'b0;
        sr_q     <= '0;
      end else if (active_q) begin
        if (hcnt_q == '0) begin
          hcnt_q <= HC_RELOAD;
          if (!sclk_q) begin
            // rising edge: capture
            sclk_q <= 1'b1;
            sr_q   <= {sr_q[MAX_W-2:0], miso_i};
            bcnt_q <= bcnt_q + 1'b1;
          end else begin
            sclk_q <= 1'b0;
            if (bcnt_q == nbits_i) begin
              active_q <= 1'b0;
              done_q   <= 1'b1;
            end
          end
        end else begin
          hcnt_q <= hcnt_q - 1'b1;
        end
      end
    end
  end

  assign sclk_o = sclk_q;
  assign done_o = done_q;
  assign raw_o  = sr_q;

endmodule

// File: rtl/adc_conv_seq_fmt.sv
`timescale 1ns/1ps
module adc_conv_seq_fmt
  import adc_conv_seq_pkg::*;
#(
  parameter int unsigned OUT_W = 32
) (
  input  logic [W_LONG-1:0] raw_i,
  input  logic [1:0]        wsel_i,
  output logic [OUT_W-1:0]  word_o
);

  always_comb begin
    word_o = '0;
    if (wsel_i[1]) begin
      word_o = {{(OUT_W-W_LONG){raw_i[W_LONG-1]}}, raw_i};
    end else if (wsel_i[0]) begin
      word_o[W_MID-1:0] = raw_i[W_MID-1:0];
    end else begin
      word_o[W_SHORT-1:0] = raw_i[W_SHORT-1:0];
    end
  end

endmodule

// File: rtl/adc_conv_seq.sv
`timescale 1ns/1ps
module adc_conv_seq
  import adc_conv_seq_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_PS  = 4000,
  parameter int unsigned SCLK_HALF      = 2,
  parameter int unsigned OUT_W          = 32,
  parameter int unsigned QUIET_NS       = 20,
  parameter int unsigned STROBE_NS      = 10,
  parameter int unsigned CONV_NS_NARROW = 420,
  parameter int unsigned TURBO_NS_NARROW = 320,
  parameter int unsigned CONV_NS_WIDE   = 500,
  parameter int unsigned TURBO_NS_WIDE  = 400
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             tied_mode_i,
  input  logic             turbo_i,
  input  logic [1:0]       width_sel_i,
  input  logic             miso_i,
  output logic             cnv_o,
  output logic             cs_no,
  output logic             sclk_o,
  output logic             busy_o,
  output logic [OUT_W-1:0] data_o,
  output logic             valid_o
);

  localparam int unsigned STROBE_CYC = ns_to_cyc(STROBE_NS, CLK_PERIOD_PS);
  localparam int unsigned QUIET_CYC  = ns_to_cyc(QUIET_NS, CLK_PERIOD_PS);
  localparam int unsigned CN_CYC = max_u(ns_to_cyc(CONV_NS_NARROW, CLK_PERIOD_PS), STROBE_CYC);
  localparam int unsigned TN_CYC = max_u(ns_to_cyc(TURBO_NS_NARROW, CLK_PERIOD_PS), STROBE_CYC);
  localparam int unsigned CW_CYC = max_u(ns_to_cyc(CONV_NS_WIDE, CLK_PERIOD_PS), STROBE_CYC);
  localparam int unsigned TW_CYC = max_u(ns_to_cyc(TURBO_NS_WIDE, CLK_PERIOD_PS), STROBE_CYC);
  localparam int unsigned MAX_CYC = max_u(max_u(CN_CYC, TN_CYC), max_u(max_u(CW_CYC, TW_CYC), QUIET_CYC));
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);
  localparam int unsigned BIT_W   = $clog2(W_LONG + 1);

  localparam logic [CNT_W-1:0] QUIET_LD = CNT_W'(QUIET_CYC - 1);
  localparam logic [CNT_W-1:0] CN_LD    = CNT_W'(CN_CYC - 1);
  localparam logic [CNT_W-1:0] TN_LD    = CNT_W'(TN_CYC - 1);
  localparam logic [CNT_W-1:0] CW_LD    = CNT_W'(CW_CYC - 1);
  localparam logic [CNT_W-1:0] TW_LD    = CNT_W'(TW_CYC - 1);

  seq_state_e       state_q;
  logic [CNT_W-1:0] conv_ld_in, conv_ld_q;
  logic [1:0]       wsel_q;
  logic             cnv_q, cs_nq, valid_q;
  logic [OUT_W-1:0] data_q;

  logic             t_load, t_zero;
  logic [CNT_W-1:0] t_val;
  logic             sh_go, sh_done;
  logic [BIT_W-1:0] nbits;
  logic [W_LONG-1:0] sh_raw;
  logic [OUT_W-1:0] fmt_word;
  logic             take_start;

  always_comb begin
    unique case ({width_sel_i[1], turbo_i})
      2'b00:   conv_ld_in = CN_LD;
      2'b01:   conv_ld_in = TN_LD;
      2'b10:   conv_ld_in = CW_LD;
      default: conv_ld_in = TW_LD;
    endcase
  end

  always_comb begin
    if (wsel_q[1])      nbits = BIT_W'(W_LONG);
    else if (wsel_q[0]) nbits = BIT_W'(W_MID);
    else                nbits = BIT_W'(W_SHORT);
  end

  assign take_start = (state_q == ST_IDLE) && start_i;

  always_comb begin
    t_load = 1'b0;
    t_val  = conv_ld_q;
    if (take_start) begin
      t_load = 1'b1;
      t_val  = tied_mode_i ? QUIET_LD : conv_ld_in;
    end else if ((state_q == ST_QUIET) && t_zero) begin
      t_load = 1'b1;
      t_val  = conv_ld_q;
    end
  end

  assign sh_go = (state_q == ST_CONV) && t_zero;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      conv_ld_q <= '0;
      wsel_q    <= '0;
      cnv_q     <= 1'b0;
      cs_nq     <= 1'b1;
      valid_q   <= 1'b0;
      data_q    <= '0;
    end else begin
      valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            conv_ld_q <= conv_ld_in;
            wsel_q    <= width_sel_i;
            if (tied_mode_i) begin
              cs_nq   <= 1'b0;
              state_q <= ST_QUIET;
            end else begin
              cnv_q   <= 1'b1;
              state_q <= ST_CONV;
            end
          end
        end
        ST_QUIET: begin
          if (t_zero) begin
            cs_nq   <= 1'b1;
            state_q <= ST_CONV;
          end
        end
        ST_CONV: begin
          if (t_zero) begin
            cs_nq   <= 1'b0;
            state_q <= ST_READ;
          end
        end
        ST_READ: begin
          if (sh_done) begin
            cs_nq   <= 1'b1;
            cnv_q   <= 1'b0;
            data_q  <= fmt_word;
            valid_q <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  adc_conv_seq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (t_load),
    .load_val_i (t_val),
    .zero_o     (t_zero)
  );

  adc_conv_seq_shifter #(.SCLK_HALF(SCLK_HALF), .MAX_W(W_LONG)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .go_i    (sh_go),
    .nbits_i (nbits),
    .miso_i  (miso_i),
    .sclk_o  (sclk_o),
    .done_o  (sh_done),
    .raw_o   (sh_raw)
  );

  adc_conv_seq_fmt #(.OUT_W(OUT_W)) u_fmt (
    .raw_i  (sh_raw),
    .wsel_i (wsel_q),
    .word_o (fmt_word)
  );

  assign cnv_o   = cnv_q;
  assign cs_no   = cs_nq;
  assign busy_o  = (state_q != ST_IDLE);
  assign data_o  = data_q;
  assign valid_o = valid_q;

endmodule

// File: rtl/adc_conv_seq_chk.sv
`timescale 1ns/1ps
module adc_conv_seq_chk
  import adc_conv_seq_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_PS = 4000,
  parameter int unsigned OUT_W         = 32,
  parameter int unsigned QUIET_NS      = 20,
  parameter int unsigned MIN_CONV_NS   = 320
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             busy_o,
  input logic             cnv_o,
  input logic             cs_no,
  input logic             sclk_o,
  input logic             valid_o,
  input logic [OUT_W-1:0] data_o
);

  localparam int unsigned QUIET_CYC = ns_to_cyc(QUIET_NS, CLK_PERIOD_PS);
  localparam int unsigned MIN_CONV  = ns_to_cyc(MIN_CONV_NS, CLK_PERIOD_PS);

  logic [15:0] hi_cnt_q, lo_cnt_q;
  logic [7:0]  edge_cnt_q;
  logic        sclk_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_cnt_q    <= '0;
      lo_cnt_q    <= '0;
      edge_cnt_q  <= '0;
      sclk_prev_q <= 1'b0;
    end else begin
      sclk_prev_q <= sclk_o;
      hi_cnt_q    <= (busy_o && cs_no)  ? hi_cnt_q + 1'b1 : '0;
      lo_cnt_q    <= (busy_o && !cs_no) ? lo_cnt_q + 1'b1 : '0;
      if (!busy_o)                    edge_cnt_q <= '0;
      else if (sclk_o && !sclk_prev_q) edge_cnt_q <= edge_cnt_q + 1'b1;
    end
  end

  AST_CNV_STARTS_SEQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cnv_o) |-> $rose(busy_o)); // R2
  AST_CNV_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && cnv_o) |=> (cnv_o || valid_o)); // R2
  AST_QUIET_TIME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(cs_no) && busy_o) |-> (lo_cnt_q >= 16'(QUIET_CYC))); // R3
  AST_CONV_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(cs_no) && $past(busy_o)) |-> (hi_cnt_q >= 16'(MIN_CONV))); // R4
  AST_EDGE_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (edge_cnt_q == 8'd14 || edge_cnt_q == 8'd16 || edge_cnt_q == 8'd18)); // R5
  AST_SCLK_SELECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> (!cs_no && busy_o)); // R6
  AST_VALID_AT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (!busy_o && cs_no && !cnv_o)); // R8
  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o); // R8
  AST_DATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(data_o)); // R8

endmodule

bind adc_conv_seq adc_conv_seq_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .busy_o  (busy_o),
  .cnv_o   (cnv_o),
  .cs_no   (cs_no),
  .sclk_o  (sclk_o),
  .valid_o (valid_o),
  .data_o  (data_o)
);

// File: tb/adc_conv_seq_tb.sv
`timescale 1ns/1ps
module adc_conv_seq_tb;

  localparam int PERIOD_PS = 4000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        tied_mode_i = 1'b0;
  logic        turbo_i = 1'b0;
  logic [1:0]  width_sel_i = 2'd0;
  logic        miso_i;
  logic        cnv_o, cs_no, sclk_o, busy_o, valid_o;
  logic [31:0] data_o;

  int errors = 0;
  int checks = 0;

  // converter model
  logic [17:0] sl_pat = '0;
  logic [17:0] sl_sr  = '0;

  always #2 clk_i = ~clk_i;

  adc_conv_seq u_dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .tied_mode_i (tied_mode_i),
    .turbo_i     (turbo_i),
    .width_sel_i (width_sel_i),
    .miso_i      (miso_i),
    .cnv_o       (cnv_o),
    .cs_no       (cs_no),
    .sclk_o      (sclk_o),
    .busy_o      (busy_o),
    .data_o      (data_o),
    .valid_o     (valid_o)
  );

  always @(negedge cs_no) sl_sr = sl_pat;
  always @(negedge sclk_o) sl_sr = {sl_sr[16:0], 1'b0};
  assign miso_i = sl_sr[17];

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic int ceil_cyc(input int ns);
    return (ns * 1000 + PERIOD_PS - 1) / PERIOD_PS;
  endfunction

  function automatic int exp_wait(input logic tb, input logic [1:0] ws);
    if (ws[1]) return tb ? ceil_cyc(400) : ceil_cyc(500);
    return tb ? ceil_cyc(320) : ceil_cyc(420);
  endfunction

  function automatic int exp_bits(input logic [1:0] ws);
    return ws[1] ? 18 : (ws[0] ? 16 : 14);
  endfunction

  function automatic logic [31:0] exp_word(input logic [31:0] pat, input logic [1:0] ws);
    int w = exp_bits(ws);
    logic [31:0] r = '0;
    for (int i = 0; i < w; i++) r[i] = pat[i];
    if (w == 18) for (int i = 18; i < 32; i++) r[i] = pat[17];
    return r;
  endfunction

  task automatic run_seq(input logic tied, input logic tb, input logic [1:0] ws,
                         input logic [31:0] pat, input logic poke, output int total);
    int w = exp_bits(ws);
    int hi = 0, pre_lo = 0, rises = 0, bad_cnv = 0, bad_sclk = 0, n = 0;
    logic seen_hi = 0, prev_sclk = 0, done = 0;
    logic [31:0] expw = exp_word(pat, ws);
    sl_pat = '0;
    for (int i = 0; i < w; i++) sl_pat[17 - i] = pat[w - 1 - i];
    @(negedge clk_i);
    tied_mode_i = tied; turbo_i = tb; width_sel_i = ws; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(busy_o == 1'b1, tied ? "R3 busy at start" : "R2 busy at start", busy_o, 1);
    if (!tied) chk(cnv_o && cs_no, "R2 cnv up, cs high at start", {cnv_o, cs_no}, 3);
    while (!done && n < 5000) begin
      if (valid_o) done = 1;
      else begin
        if (busy_o && cs_no) begin hi++; seen_hi = 1; end
        if (busy_o && !cs_no && !seen_hi) pre_lo++;
        if (busy_o && (cnv_o != !tied)) bad_cnv++;
        if (sclk_o && cs_no) bad_sclk++;
        if (sclk_o && !prev_sclk) rises++;
        prev_sclk = sclk_o;
        n++;
        if (poke && n == 20) start_i = 1'b1;
        if (poke && n == 21) start_i = 1'b0;
        if (poke && n == hi + pre_lo + 10 && seen_hi && !cs_no) start_i = 1'b1;
        @(negedge clk_i);
        if (poke) start_i = 1'b0;
      end
    end
    total = n;
    chk(done, "R8 valid seen", done, 1);
    chk(hi == exp_wait(tb, ws), "R4 conversion wait", hi, exp_wait(tb, ws));
    if (tied) begin
      chk(pre_lo == ceil_cyc(20), "R3 quiet time", pre_lo, ceil_cyc(20));
      chk(bad_cnv == 0, "R3 cnv stays low", bad_cnv, 0);
    end else begin
      chk(pre_lo == 0, "R2 cs high from start", pre_lo, 0);
      chk(bad_cnv == 0, "R2 cnv held high", bad_cnv, 0);
    end
    chk(rises == w, "R5 sclk edge count", rises, w);
    chk(bad_sclk == 0, "R6 sclk only while selected", bad_sclk, 0);
    chk(data_o == expw, ws[1] ? "R7 sign-extended result" : "R7 zero-extended result", data_o, expw);
    chk(!busy_o && cs_no && !cnv_o, "R8 idle with valid", {busy_o, cs_no, cnv_o}, 3'b010);
    @(negedge clk_i);
    chk(!valid_o, "R8 single valid pulse", valid_o, 0);
    repeat (6) @(negedge clk_i);
    chk(data_o == expw, "R8 data holds", data_o, expw);
    chk(!busy_o && !valid_o, "R9 no restart after sequence", {busy_o, valid_o}, 0);
  endtask

  task automatic t_reset;
    chk(cnv_o == 0 && cs_no == 1 && sclk_o == 0, "R1 line levels", {cnv_o, cs_no, sclk_o}, 3'b010);
    chk(busy_o == 0 && valid_o == 0 && data_o == 0, "R1 status and data", {busy_o, valid_o, data_o}, 0);
  endtask

  task automatic t_sep_normal;
    int t; run_seq(1'b0, 1'b0, 2'd1, 32'h0000_A5C3, 1'b0, t);
  endtask
  task automatic t_sep_turbo_14;
    int t; run_seq(1'b0, 1'b1, 2'd0, 32'h0000_3FFF, 1'b0, t);
  endtask
  task automatic t_tied_18_negative;
    int t; run_seq(1'b1, 1'b0, 2'd2, 32'h0002_0001, 1'b0, t);
  endtask
  task automatic t_tied_18_positive_turbo;
    int t; run_seq(1'b1, 1'b1, 2'd3, 32'h0001_5A5A, 1'b0, t);
  endtask
  task automatic t_tied_16_msb_set;
    int t; run_seq(1'b1, 1'b0, 2'd1, 32'h0000_8001, 1'b0, t);
  endtask
  task automatic t_start_ignored;
    int base, poked;
    run_seq(1'b0, 1'b0, 2'd2, 32'h0003_0F0F, 1'b0, base);
    run_seq(1'b0, 1'b0, 2'd2, 32'h0003_0F0F, 1'b1, poked);
    chk(base == poked, "R9 length unchanged by start while busy", poked, base);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog act=%0h exp=%0h", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_sep_normal();
    t_sep_turbo_14();
    t_tied_18_negative();
    t_tied_18_positive_turbo();
    t_tied_16_msb_set();
    t_start_ignored();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule